// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Idle Queueing

This block turns characters into an asynchronous serial bit stream on a single line. Each bit lasts one baud tick: a single-cycle strobe on `baud_tick` that comes from a baud generator outside the block. Characters pass through a one-entry holding buffer into a shift register. Each ordinary frame has a low start bit, 8, 9 or 10 data bits sent least significant bit first, and one or two high stop bits. Between frames the line rests high.

Besides ordinary data, the block can send two special characters:

- A break character holds the line low.
- An idle character holds the line high for a full frame time.

Software can request either one through control inputs. A rising edge on `brk_req` asks for a break. A rising edge on `tx_en` asks for an idle character. The data path can also request them: a buffer write with the marker bit set is sent as a break when the payload is all zeros and as an idle character when the payload is all ones. This lets a DMA stream mix special characters into ordinary data.

Turning `tx_en` off does not stop the character on the wire. The current character finishes, and no new one starts until the enable returns.

Top module: `sertx_core`

## Requirements
- R1: After reset, and whenever a character ends with nothing allowed to follow, `tx_out` is 1 and `tx_done` is 1; both hold until a new character is loaded.
- R2: A data frame is sent as one 0 start bit, then D payload bits least significant bit first, then S stop bits of 1. D is 8, 9 or 10 for `len_sel` = 0, 1 or 2 (3 acts as 2). S is 1 when `two_stop` = 0 and 2 when it is 1. Each bit lasts from one baud tick to the next, and back-to-back characters leave no gap.
- R3: `buf_empty` is 1 after reset. An accepted write clears it, and it sets again on the tick at which the buffer content moves into the shifter. A write while the buffer is full is dropped.
- R4: `tx_done` clears on the tick at which any character (data, break or idle) is loaded into the shifter.
- R5: When `tx_en` is 0, the character in progress completes unchanged and no further character is loaded. The buffer keeps its content.
- R6: A rising edge of `brk_req` queues one break character. Unless R8 applies, a break holds `tx_out` at 0 for exactly the frame length 1+D+S bit times.
- R7: If `brk_req` is still 1 on the tick at which a queued break is loaded, another break is queued.
- R8: With `brk_long` = 1, every break (from a control request or from a marker write) lasts 13 bit times.
- R9: A write with `wr_data[10]` = 1 is handled by its low D payload bits. If they are all 0, it is sent as a break. If they are all 1, it is sent as an idle character: 1+D+S bit times of 1 with `tx_done` held at 0. Any other payload is sent as ordinary data.
- R10: A rising edge of `tx_en` queues one idle character, including the first enable after reset.
- R11: When the shifter frees, a queued control break goes first, then a queued control idle, then the buffer content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Single-cycle strobe, one per bit time |
| tx_en | input | 1 | Transmitter enable; a rising edge queues an idle character |
| brk_req | input | 1 | Send-break control; a rising edge queues a break |
| brk_long | input | 1 | Selects 13-bit-time breaks |
| len_sel | input | 2 | Data length select: 0 → 8, 1 → 9, 2 or 3 → 10 bits |
| two_stop | input | 1 | 1 selects two stop bits |
| wr_valid | input | 1 | Write strobe into the holding buffer |
| wr_data | input | 11 | Payload in bits 9:0, special-character marker in bit 10 |
| tx_out | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer is empty |
| tx_done | output | 1 | Transmitter idle, all characters sent |

## Verification
The embedded properties check the following on every cycle:

- `tx_done` never coexists with a busy shifter, and a finished line rests high.
- A break keeps the line low for as long as it occupies the shifter.
- No load happens while the enable is low.
- A held break request re-queues, and an enable edge queues an idle character.
- A write to an empty buffer fills it, and a full buffer keeps its payload until it is taken.

Some behaviours can only be shown by the bench's scenarios:

- The exact bit order and frame length for every data-length and stop-bit combination.
- The total break length, and the break counts produced by a pulsed versus a held request.
- The classification of marker writes.
- The order in which break, idle and buffered data leave when all three wait together.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   // Kind of character waiting in the holding buffer
   typedef enum logic [1:0] {
      CH_DATA = 2'd0,
      CH_BRK  = 2'd1,
      CH_IDLE = 2'd2
   } ch_kind_t;

endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf
   import sertx_pkg::*;
#(
   parameter int DATA_MAX = 10,
   parameter int CNT_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_valid,
   input  logic [DATA_MAX:0]   wr_data,
   input  logic [CNT_W-1:0]    dbits,
   input  logic                take,
   output logic                full,
   output ch_kind_t            kind,
   output logic [DATA_MAX-1:0] data
);

   logic [DATA_MAX-1:0] mask;
   logic [DATA_MAX-1:0] payload;
   ch_kind_t            wr_kind;

   assign payload = wr_data[DATA_MAX-1:0];

   // Active payload bits for the configured data length
   for (genvar g = 0; g < DATA_MAX; g++) begin : g_mask
      assign mask[g] = (CNT_W'(g) < dbits);
   end

   // Classify a write; a marker only matters with a uniform payload
   always_comb begin
      wr_kind = CH_DATA;
      if (wr_data[DATA_MAX]) begin
         if ((payload & mask) == '0)
            wr_kind = CH_BRK;
         else if ((payload | ~mask) == '1)
            wr_kind = CH_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         kind <= CH_DATA;
         data <= '0;
      end else if (wr_valid && (!full || take)) begin
         full <= 1'b1;
         kind <= wr_kind;
         data <= payload;
      end else if (take) begin
         full <= 1'b0;
      end
   end

   AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !full) |=> full); // R3
   AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !take) |=> (full && $stable(data))); // R3

endmodule

// File: rtl/sertx_ctlq.sv
module sertx_ctlq (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic brk_req,
   input  logic take_brk,
   input  logic take_idle,
   output logic brk_pend,
   output logic idle_pend
);

   logic brk_q;
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         brk_q     <= 1'b0;
         en_q      <= 1'b0;
         brk_pend  <= 1'b0;
         idle_pend <= 1'b0;
      end else begin
         brk_q <= brk_req;
         en_q  <= tx_en;
         // A break still requested at load time re-queues itself
         if (take_brk)
            brk_pend <= brk_req;
         else if (brk_req && !brk_q)
            brk_pend <= 1'b1;
         if (take_idle)
            idle_pend <= 1'b0;
         else if (tx_en && !en_q)
            idle_pend <= 1'b1;
      end
   end

   AST_BRK_REQUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_brk && brk_req) |=> brk_pend); // R7
   AST_IDLE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tx_en) && !take_idle) |=> idle_pend); // R10

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
   parameter int SHIFT_W = 13,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               load,
   input  logic [SHIFT_W-1:0] load_bits,
   input  logic [CNT_W-1:0]   load_len,
   output logic               free,
   output logic               busy,
   output logic               done,
   output logic               tx_out
);

   logic [SHIFT_W-1:0] shreg;
   logic [CNT_W-1:0]   cnt;

   // The shifter may take a new character on the tick that ends the last bit
   assign free   = tick && (!busy || cnt == CNT_W'(1));
   assign tx_out = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '1;
         cnt   <= '0;
         busy  <= 1'b0;
         done  <= 1'b1;
      end else if (tick) begin
         if (load) begin
            shreg <= load_bits;
            cnt   <= load_len;
            busy  <= 1'b1;
            done  <= 1'b0;
         end else if (busy) begin
            if (cnt == CNT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
               cnt  <= '0;
            end else begin
               cnt   <= cnt - CNT_W'(1);
               shreg <= {1'b1, shreg[SHIFT_W-1:1]};
            end
         end
      end
   end

   AST_DONE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> tx_out); // R1
   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done); // R4
   AST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> free); // R2
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cnt != '0 && cnt <= CNT_W'(SHIFT_W))); // R2

endmodule

// File: rtl/sertx_core.sv
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_MIN = 8,
   parameter int DATA_MAX = 10,
   parameter int LONG_BRK = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              tx_en,
   input  logic              brk_req,
   input  logic              brk_long,
   input  logic [1:0]        len_sel,
   input  logic              two_stop,
   input  logic              wr_valid,
   input  logic [DATA_MAX:0] wr_data,
   output logic              tx_out,
   output logic              buf_empty,
   output logic              tx_done
);

   localparam int FRAME_W = DATA_MAX + 3;
   localparam int SHIFT_W = (FRAME_W > LONG_BRK) ? FRAME_W : LONG_BRK;
   localparam int CNT_W   = $clog2(SHIFT_W + 1);

   if (DATA_MIN < 1 || DATA_MAX < DATA_MIN) begin : g_bad_len
      $error("sertx_core: data length range is invalid");
   end
   if (LONG_BRK < 2) begin : g_bad_brk
      $error("sertx_core: long break must span at least two bits");
   end

   logic [CNT_W-1:0]    dbits, flen, load_len;
   logic [SHIFT_W-1:0]  data_frame, load_bits;
   logic                buf_full, free, go, busy, load, is_brk, cur_brk;
   logic                brk_pend, idle_pend, take_brk, take_idle, take_buf;
   ch_kind_t            buf_kind;
   logic [DATA_MAX-1:0] buf_data;

   // Configured data length and frame length
   always_comb begin
      int d;
      d = DATA_MIN + int'(len_sel);
      if (d > DATA_MAX) d = DATA_MAX;
      dbits = CNT_W'(d);
      flen  = CNT_W'(d + (two_stop ? 3 : 2));
   end

   // Frame image: start bit, payload LSB first, ones above
   assign data_frame[0] = 1'b0;
   for (genvar g = 1; g < SHIFT_W; g++) begin : g_frame
      if (g <= DATA_MAX) begin : g_pay
         assign data_frame[g] = (CNT_W'(g - 1) < dbits) ? buf_data[g-1] : 1'b1;
      end else begin : g_stop
         assign data_frame[g] = 1'b1;
      end
   end

   // Source selection when the shifter frees: break, idle, buffer
   assign go        = free && tx_en;
   assign take_brk  = go && brk_pend;
   assign take_idle = go && !brk_pend && idle_pend;
   assign take_buf  = go && !brk_pend && !idle_pend && buf_full;
   assign load      = take_brk || take_idle || take_buf;
   assign buf_empty = !buf_full;

   always_comb begin
      load_bits = data_frame;
      is_brk    = 1'b0;
      if (take_brk) begin
         load_bits = '0;
         is_brk    = 1'b1;
      end else if (take_idle) begin
         load_bits = '1;
      end else if (buf_kind == CH_BRK) begin
         load_bits = '0;
         is_brk    = 1'b1;
      end else if (buf_kind == CH_IDLE) begin
         load_bits = '1;
      end
      load_len = (is_brk && brk_long) ? CNT_W'(LONG_BRK) : flen;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cur_brk <= 1'b0;
      else if (load) cur_brk <= is_brk;
   end

   sertx_holdbuf #(.DATA_MAX(DATA_MAX), .CNT_W(CNT_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .dbits(dbits), .take(take_buf), .full(buf_full), .kind(buf_kind),
      .data(buf_data));

   sertx_ctlq u_ctl (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
      .take_brk(take_brk), .take_idle(take_idle), .brk_pend(brk_pend),
      .idle_pend(idle_pend));

   sertx_shifter #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) u_shf (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(load),
      .load_bits(load_bits), .load_len(load_len), .free(free), .busy(busy),
      .done(tx_done), .tx_out(tx_out));

   AST_BRK_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_brk) |-> !tx_out); // R6
   AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> tx_en); // R5

endmodule

// File: tb/sertx_core_bench.sv
`timescale 1ns/1ps
module sertx_core_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        baud_tick = 1'b0;
   logic        tx_en = 1'b0;
   logic        brk_req = 1'b0;
   logic        brk_long = 1'b0;
   logic [1:0]  len_sel = 2'd0;
   logic        two_stop = 1'b0;
   logic        wr_valid = 1'b0;
   logic [10:0] wr_data = '0;
   logic        tx_out, buf_empty, tx_done;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   sertx_core u_sertx_core (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
      .brk_req(brk_req), .brk_long(brk_long), .len_sel(len_sel),
      .two_stop(two_stop), .wr_valid(wr_valid), .wr_data(wr_data),
      .tx_out(tx_out), .buf_empty(buf_empty), .tx_done(tx_done));

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // One bit time: tick strobe, then sample at a falling edge
   task automatic step();
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr(input logic [10:0] v);
      @(negedge clk) begin wr_valid = 1'b1; wr_data = v; end
      @(negedge clk) wr_valid = 1'b0;
   endtask

   task automatic brk_pulse();
      @(negedge clk) brk_req = 1'b1;
      @(negedge clk) brk_req = 1'b0;
   endtask

   task automatic set_en(input logic v);
      @(negedge clk) tx_en = v;
      @(negedge clk);
   endtask

   function automatic int dlen(input int ls);
      return (ls >= 2) ? 10 : 8 + ls;
   endfunction

   function automatic int flen(input int ls, input int ts);
      return dlen(ls) + 2 + ts;
   endfunction

   function automatic logic [12:0] dframe(input int d, input logic [9:0] v);
      logic [12:0] f;
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < d; i++) f[i+1] = v[i];
      return f;
   endfunction

   // Checks each bit of a character on the line; the last step ends it
   task automatic expect_frame(input logic [12:0] f, input int len, input string tag);
      for (int i = 0; i < len; i++) begin
         chk(tx_out, f[i], tag);
         step();
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_out, 1, "R1 reset line");
      chk(tx_done, 1, "R1 reset done");
      chk(buf_empty, 1, "R3 reset empty");

      // R10: first enable queues an idle character
      set_en(1'b1);
      step();
      chk(tx_done, 0, "R4 idle load");
      expect_frame('1, 10, "R10 idle frame");
      chk(tx_done, 1, "R1 after idle");
      chk(tx_out, 1, "R1 line high");

      // R2 sweep over all lengths and stop counts
      for (int ls = 0; ls < 3; ls++) begin
         for (int ts = 0; ts < 2; ts++) begin
            for (int k = 0; k < 3; k++) begin
               logic [9:0] v;
               v = 10'h2B5 ^ 10'(k * 10'h0F3) ^ 10'(ls * 10'h111);
               len_sel = 2'(ls);
               two_stop = 1'(ts);
               wr({1'b0, v});
               chk(buf_empty, 0, "R3 write clears");
               step();
               chk(buf_empty, 1, "R3 move sets");
               chk(tx_done, 0, "R4 data load");
               expect_frame(dframe(dlen(ls), v), flen(ls, ts), "R2 data frame");
               chk(tx_done, 1, "R1 end of data");
            end
         end
      end

      // len_sel 3 acts as 10 bits
      len_sel = 2'd3; two_stop = 1'b0;
      wr(11'h2C3);
      step();
      expect_frame(dframe(10, 10'h2C3), 12, "R2 len_sel 3");

      // R3: write while full is dropped
      len_sel = 2'd0;
      wr(11'h0A5);
      wr(11'h05A);
      step();
      expect_frame(dframe(8, 10'h0A5), 10, "R3 first kept");
      chk(buf_empty, 1, "R3 second dropped");
      chk(tx_done, 1, "R3 nothing more");

      // R2: back-to-back without gap
      wr(11'h0C6);
      step();
      wr(11'h039);
      expect_frame(dframe(8, 10'h0C6), 10, "R2 first of pair");
      chk(buf_empty, 1, "R3 second moved");
      chk(tx_done, 0, "R2 no gap");
      expect_frame(dframe(8, 10'h039), 10, "R2 second of pair");
      chk(tx_done, 1, "R1 pair done");

      // R6: pulsed break, 9-bit frame
      len_sel = 2'd1;
      brk_pulse();
      step();
      chk(tx_done, 0, "R4 break load");
      expect_frame('0, 11, "R6 break length");
      chk(tx_out, 1, "R6 single break");
      chk(tx_done, 1, "R6 single break done");

      // R7: held break re-queues once more
      @(negedge clk) brk_req = 1'b1;
      step();
      @(negedge clk) brk_req = 1'b0;
      expect_frame('0, 11, "R7 first break");
      chk(tx_done, 0, "R7 second queued");
      expect_frame('0, 11, "R7 second break");
      chk(tx_done, 1, "R7 no third");

      // R8: long break
      len_sel = 2'd0;
      brk_long = 1'b1;
      brk_pulse();
      step();
      expect_frame('0, 13, "R8 long break");
      chk(tx_out, 1, "R8 ends at 13");
      wr(11'h400);
      step();
      expect_frame('0, 13, "R8 marker long break");
      chk(tx_done, 1, "R8 done");
      brk_long = 1'b0;

      // R9: marker writes
      wr(11'h400);
      step();
      expect_frame('0, 10, "R9 marker break");
      chk(tx_done, 1, "R9 break done");
      wr(11'h4FF);
      step();
      chk(tx_done, 0, "R9 idle busy");
      expect_frame('1, 10, "R9 marker idle");
      chk(tx_done, 1, "R9 idle done");
      len_sel = 2'd1;
      wr(11'h4FF);
      step();
      expect_frame(dframe(9, 10'h0FF), 11, "R9 mixed is data");
      len_sel = 2'd2; two_stop = 1'b1;
      wr(11'h7FF);
      step();
      chk(tx_done, 0, "R9 idle 10 busy");
      expect_frame('1, 13, "R9 idle 10-bit");
      chk(tx_done, 1, "R9 idle 10 done");

      // R5: disable mid-character, then R10/R11 on re-enable
      len_sel = 2'd0; two_stop = 1'b0;
      wr(11'h0B2);
      step();
      set_en(1'b0);
      wr(11'h04D);
      expect_frame(dframe(8, 10'h0B2), 10, "R5 finishes");
      chk(tx_done, 1, "R5 stopped");
      step(); step();
      chk(tx_out, 1, "R5 no start");
      chk(buf_empty, 0, "R5 buffer kept");
      set_en(1'b1);
      step();
      chk(buf_empty, 0, "R11 idle before data");
      chk(tx_done, 0, "R10 idle loaded");
      expect_frame('1, 10, "R10 idle on re-enable");
      chk(buf_empty, 1, "R11 data after idle");
      expect_frame(dframe(8, 10'h04D), 10, "R11 data third");
      chk(tx_done, 1, "R1 sequence done");

      // R11: break, idle and data all waiting
      set_en(1'b0);
      wr(11'h0E1);
      brk_pulse();
      set_en(1'b1);
      step();
      chk(buf_empty, 0, "R11 break first");
      expect_frame('0, 10, "R11 break frame");
      chk(buf_empty, 0, "R11 idle second");
      expect_frame('1, 10, "R11 idle frame");
      chk(buf_empty, 1, "R11 data last");
      expect_frame(dframe(8, 10'h0E1), 10, "R11 data frame");
      chk(tx_done, 1, "R1 final idle");
      chk(tx_out, 1, "R1 final line");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule